// File: doc/BRIEF.md
# Parallel Synchronous Data Port

This block is the device-side end of a parallel synchronous data link. An external source supplies the parallel data clock; the port samples that clock with its own system clock, finds the selected edge, and on each such edge either captures a word from the parallel bus (receive) or drives the next word onto it (transmit). Words are 8 or 16 bits wide. A small word FIFO sits between the bus and the system side: it offers a valid/ready output stream in receive and accepts a valid/ready input stream in transmit.

Two optional handshake functions travel with the data. One says "data on the bus is valid" and comes from the transmitter. The other says "receiver can take a word" and comes from the receiver. Each has its own polarity bit. A 3-bit handshake code chooses which of the two is used and whether each sits on its own pin, is moved to the other pin, or shares one pin with the other function. A shared pin is driven by this port only during the half of the parallel clock period that follows the active edge, and is read at the active edge.

Configuration comes in on plain inputs. It is copied into the port when the enable input rises and is held while enabled. Dropping the enable empties the FIFO.

Top module: `par_sync_port`

## Requirements
- R1: While disabled (after reset, or when `cfg_enable` is low) the port drives nothing: `pdata_oe`, `pin_de_oe`, `pin_rdy_oe`, `m_valid` and `s_ready` are all 0.
- R2: The active edge of `pclk` is rising when `cfg_edge_sel` XOR `cfg_dir_tx` is 1, and falling otherwise. So in receive (`cfg_dir_tx`=0), data is captured on the falling edge for `cfg_edge_sel`=0 and on the rising edge for 1. In transmit the two edges swap.
- R3: `cfg_width`=3 moves all 16 bits. Codes 0, 1 and 2 move only bits 7:0: received words carry zeros in bits 15:8, and transmitted words drive zeros there.
- R4: In receive with the ready function on, ready is active while the FIFO has room for a word and inactive once it holds `FIFO_DEPTH` words. The pin level for active is `cfg_rdy_pol` (1 = high means ready, 0 = low means ready).
- R5: In receive with the data-enable function on, a word is captured at an active edge only if the data-enable pin is at its active level. The active level is `cfg_de_pol`: 1 = high means valid, 0 = low means valid.
- R6: In transmit, at each active edge the port pops a word from the FIFO onto `pdata_out` and asserts data-enable. If the FIFO is empty, it asserts no data-enable and holds `pdata_out`. Edges of the other polarity change nothing.
- R7: In transmit with the ready function on, no word is popped at an active edge where the ready pin is inactive, and data-enable is inactive after that edge.
- R8: Handshake code `cfg_hs` 0 = none, 1 = ready only, 2 = data-enable only, 3 = both on their home pins (data-enable on `pin_de_*`, ready on `pin_rdy_*`), 5 = ready only on the data-enable pin, 6 = data-enable only on the ready pin. A moved function keeps its own polarity bit.
- R9: Code 4 puts both functions on the ready pin; code 7 puts both on the data-enable pin. On the shared pin the port drives its own function (ready in receive, data-enable in transmit) only while `pclk` is at the level it takes after the active edge. It leaves the pin undriven in the other half, and samples the peer's function there at the active edge.
- R10: Clearing `cfg_enable` flushes the FIFO. After re-enabling, no old word is delivered.
- R11: Configuration is copied on the rising edge of `cfg_enable`. Changes to any configuration input while enabled have no effect.
- R12: With code 0, both handshake pins are undriven and every active edge moves a word, as long as the FIFO allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Port enable; falling flushes FIFO, rising loads configuration |
| cfg_edge_sel | input | 1 | Parallel clock edge select |
| cfg_dir_tx | input | 1 | 0 receive, 1 transmit |
| cfg_width | input | 2 | Word width code (3 = 16 bit, else 8 bit) |
| cfg_de_pol | input | 1 | Data-enable active level |
| cfg_rdy_pol | input | 1 | Ready active level |
| cfg_hs | input | 3 | Handshake function and pin routing code |
| pclk | input | 1 | External parallel data clock |
| pdata_in | input | 16 | Parallel bus input |
| pdata_out | output | 16 | Parallel bus output |
| pdata_oe | output | 1 | Parallel bus output enable |
| pin_de_in | input | 1 | Data-enable pin input |
| pin_de_out | output | 1 | Data-enable pin output value |
| pin_de_oe | output | 1 | Data-enable pin output enable |
| pin_rdy_in | input | 1 | Ready pin input |
| pin_rdy_out | output | 1 | Ready pin output value |
| pin_rdy_oe | output | 1 | Ready pin output enable |
| m_valid | output | 1 | Received word available |
| m_data | output | 16 | Received word |
| m_ready | input | 1 | System takes received word |
| s_valid | input | 1 | System offers word to send |
| s_data | input | 16 | Word to send |
| s_ready | output | 1 | Port accepts word to send |

## Verification
Receive is first tried with data that changes between the two parallel clock edges. This separates capture on the selected edge from capture on the wrong one, and separates full-width from narrow-lane width codes, since the word's two bytes differ. Handshake patterns then hold the peer's pin at its inactive and then its active level, once on the home pin and once on the moved or shared pin. Only the routing and polarity named by the code can let the word through. Filling the FIFO to its depth shows the ready level flipping exactly at full. Configuration writes made while enabled, and a disable between capture and read, show the freeze and the flush.

// File: rtl/psp_pkg.sv
package psp_pkg;

    typedef enum logic [1:0] {
        WIDTH_NARROW = 2'd0,
        WIDTH_RSV1   = 2'd1,
        WIDTH_RSV2   = 2'd2,
        WIDTH_WIDE   = 2'd3
    } width_e;

    typedef struct packed {
        logic       edge_sel;
        logic       dir_tx;
        width_e     width;
        logic       de_pol;
        logic       rdy_pol;
        logic [2:0] hs;
    } cfg_t;

    typedef struct packed {
        logic use_rdy;
        logic use_de;
        logic rdy_on_de_pin;
        logic de_on_rdy_pin;
        logic shared;
    } hs_route_t;

    function automatic hs_route_t decode_hs(logic [2:0] code);
        hs_route_t r;
        r = '0;
        case (code)
            3'd1: r.use_rdy = 1'b1;
            3'd2: r.use_de  = 1'b1;
            3'd3: begin r.use_rdy = 1'b1; r.use_de = 1'b1; end
            3'd4: begin
                r.use_rdy = 1'b1; r.use_de = 1'b1;
                r.de_on_rdy_pin = 1'b1; r.shared = 1'b1;
            end
            3'd5: begin r.use_rdy = 1'b1; r.rdy_on_de_pin = 1'b1; end
            3'd6: begin r.use_de = 1'b1; r.de_on_rdy_pin = 1'b1; end
            3'd7: begin
                r.use_rdy = 1'b1; r.use_de = 1'b1;
                r.rdy_on_de_pin = 1'b1; r.shared = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // active flag -> pin level for a given active level
    function automatic logic to_level(logic active, logic pol);
        return ~(active ^ pol);
    endfunction

    // pin level -> active flag for a given active level
    function automatic logic from_level(logic level, logic pol);
        return ~(level ^ pol);
    endfunction

    function automatic logic edge_is_rising(cfg_t c);
        return c.edge_sel ^ c.dir_tx;
    endfunction

    function automatic logic is_wide(width_e w);
        return w == WIDTH_WIDE;
    endfunction

endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/psp_fifo.sv
module psp_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/psp_hs_map.sv
module psp_hs_map
    import psp_pkg::*;
(
    input  cfg_t cfg,
    input  logic enabled,
    input  logic drive_phase,
    input  logic own_active,
    input  logic de_pin_s,
    input  logic rdy_pin_s,
    output logic de_pin_out,
    output logic de_pin_oe,
    output logic rdy_pin_out,
    output logic rdy_pin_oe,
    output logic peer_ok
);
    hs_route_t route;
    logic own_used, own_on_de, own_pol;
    logic peer_used, peer_on_de, peer_pol;
    logic own_lvl, peer_lvl, phase_ok;

    always_comb begin
        route = decode_hs(cfg.hs);
        if (cfg.dir_tx) begin
            own_used   = route.use_de;
            own_on_de  = !route.de_on_rdy_pin;
            own_pol    = cfg.de_pol;
            peer_used  = route.use_rdy;
            peer_on_de = route.rdy_on_de_pin;
            peer_pol   = cfg.rdy_pol;
        end else begin
            own_used   = route.use_rdy;
            own_on_de  = route.rdy_on_de_pin;
            own_pol    = cfg.rdy_pol;
            peer_used  = route.use_de;
            peer_on_de = !route.de_on_rdy_pin;
            peer_pol   = cfg.de_pol;
        end

        own_lvl  = to_level(own_active, own_pol);
        phase_ok = !route.shared || drive_phase;

        de_pin_oe  = enabled && own_used && own_on_de && phase_ok;
        rdy_pin_oe = enabled && own_used && !own_on_de && phase_ok;
        de_pin_out  = de_pin_oe  ? own_lvl : 1'b0;
        rdy_pin_out = rdy_pin_oe ? own_lvl : 1'b0;

        peer_lvl = peer_on_de ? de_pin_s : rdy_pin_s;
        peer_ok  = peer_used ? from_level(peer_lvl, peer_pol) : 1'b1;
    end
endmodule

// File: rtl/par_sync_port.sv
module par_sync_port
    import psp_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FIFO_DEPTH  = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned LANE_W = DATA_W / 2,
    localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned SYNC_W = DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_edge_sel,
    input  logic              cfg_dir_tx,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_de_pol,
    input  logic              cfg_rdy_pol,
    input  logic [2:0]        cfg_hs,
    input  logic              pclk,
    input  logic [DATA_W-1:0] pdata_in,
    output logic [DATA_W-1:0] pdata_out,
    output logic              pdata_oe,
    input  logic              pin_de_in,
    output logic              pin_de_out,
    output logic              pin_de_oe,
    input  logic              pin_rdy_in,
    output logic              pin_rdy_out,
    output logic              pin_rdy_oe,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready
);
    // ---------------- configuration capture ----------------
    cfg_t cfg_in, cfg_q;
    logic en_q;

    assign cfg_in = '{edge_sel: cfg_edge_sel, dir_tx: cfg_dir_tx,
                      width: width_e'(cfg_width), de_pol: cfg_de_pol,
                      rdy_pol: cfg_rdy_pol, hs: cfg_hs};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cfg_q <= '0;
        end else begin
            en_q <= cfg_enable;
            if (cfg_enable && !en_q) cfg_q <= cfg_in;
        end
    end

    // ---------------- input synchronisation ----------------
    logic [SYNC_W-1:0] sync_q;
    logic              pclk_s, pclk_prev, de_pin_s, rdy_pin_s;
    logic [DATA_W-1:0] pdata_s;

    psp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pclk, pin_de_in, pin_rdy_in, pdata_in}),
        .q   (sync_q)
    );

    assign {pclk_s, de_pin_s, rdy_pin_s, pdata_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) pclk_prev <= 1'b0;
        else     pclk_prev <= pclk_s;
    end

    logic act_rising, act_edge, drive_phase;
    assign act_rising  = edge_is_rising(cfg_q);
    assign act_edge    = en_q && (act_rising ? (pclk_s && !pclk_prev)
                                             : (!pclk_s && pclk_prev));
    assign drive_phase = (pclk_s == act_rising);

    function automatic logic [DATA_W-1:0] shape(logic [DATA_W-1:0] w, logic wide);
        return wide ? w : {{(DATA_W-LANE_W){1'b0}}, w[LANE_W-1:0]};
    endfunction

    // ---------------- word FIFO ----------------
    logic              f_push, f_pop, f_full, f_empty;
    logic [DATA_W-1:0] f_wdata, f_rdata;
    logic [CNT_W-1:0]  f_count;
    logic              peer_ok, own_active;
    logic              rx_cap, tx_send, wide;

    assign wide    = is_wide(cfg_q.width);
    assign rx_cap  = act_edge && !cfg_q.dir_tx && peer_ok && !f_full;
    assign tx_send = act_edge && cfg_q.dir_tx && peer_ok && !f_empty;

    assign s_ready = en_q && cfg_q.dir_tx && !f_full;
    assign m_valid = en_q && !cfg_q.dir_tx && !f_empty;
    assign m_data  = f_rdata;

    assign f_push  = cfg_q.dir_tx ? (s_valid && s_ready) : rx_cap;
    assign f_pop   = cfg_q.dir_tx ? tx_send : (m_valid && m_ready);
    assign f_wdata = cfg_q.dir_tx ? s_data : shape(pdata_s, wide);

    psp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (!en_q),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .full  (f_full),
        .empty (f_empty),
        .count (f_count)
    );

    // ---------------- transmit output stage ----------------
    logic [DATA_W-1:0] out_q;
    logic              de_q;

    always_ff @(posedge clk) begin
        if (rst || !en_q) begin
            out_q <= '0;
            de_q  <= 1'b0;
        end else if (act_edge && cfg_q.dir_tx) begin
            de_q <= tx_send;
            if (tx_send) out_q <= shape(f_rdata, wide);
        end
    end

    assign pdata_out  = out_q;
    assign pdata_oe   = en_q && cfg_q.dir_tx;
    assign own_active = cfg_q.dir_tx ? de_q : !f_full;

    // ---------------- handshake pins ----------------
    psp_hs_map u_hs (
        .cfg         (cfg_q),
        .enabled     (en_q),
        .drive_phase (drive_phase),
        .own_active  (own_active),
        .de_pin_s    (de_pin_s),
        .rdy_pin_s   (rdy_pin_s),
        .de_pin_out  (pin_de_out),
        .de_pin_oe   (pin_de_oe),
        .rdy_pin_out (pin_rdy_out),
        .rdy_pin_oe  (pin_rdy_oe),
        .peer_ok     (peer_ok)
    );
endmodule

// File: rtl/psp_checker.sv
module psp_checker
    import psp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             enabled,
    input cfg_t             cfg_q,
    input logic             pdata_oe,
    input logic             pin_de_oe,
    input logic             pin_rdy_oe,
    input logic             m_valid,
    input logic             s_ready,
    input logic             f_full,
    input logic [CNT_W-1:0] f_count
);
    // R1: nothing driven or offered while disabled
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> (!pdata_oe && !pin_de_oe && !pin_rdy_oe && !m_valid && !s_ready));

    // R4: the FIFO never holds more than its depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        f_count <= CNT_W'(DEPTH));

    // R6: the system side is never offered a slot when the FIFO is full
    a_r6_no_accept_full: assert property (@(posedge clk) disable iff (rst)
        f_full |-> !s_ready);

    // R6: receive and transmit streams never active together
    a_r6_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(m_valid && s_ready));

    // R10: disabled port is empty one cycle later
    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> (f_count == '0));

    // R11: captured configuration holds while enabled
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (enabled && $past(enabled)) |-> $stable(cfg_q));
endmodule

bind par_sync_port psp_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_psp_checker (
    .clk        (clk),
    .rst        (rst),
    .enabled    (en_q),
    .cfg_q      (cfg_q),
    .pdata_oe   (pdata_oe),
    .pin_de_oe  (pin_de_oe),
    .pin_rdy_oe (pin_rdy_oe),
    .m_valid    (m_valid),
    .s_ready    (s_ready),
    .f_full     (f_full),
    .f_count    (f_count)
);

// File: tb/test_par_sync_port.sv
module test_par_sync_port;
    localparam int DW    = 16;
    localparam int DEPTH = 4;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 0, cfg_edge_sel = 0, cfg_dir_tx = 0;
    logic [1:0] cfg_width = 0;
    logic cfg_de_pol = 0, cfg_rdy_pol = 0;
    logic [2:0] cfg_hs = 0;
    logic pclk = 0;
    logic [DW-1:0] pdata_in = 0, s_data = 0;
    logic pin_de_in = 0, pin_rdy_in = 0, m_ready = 0, s_valid = 0;
    logic [DW-1:0] pdata_out, m_data;
    logic pdata_oe, pin_de_out, pin_de_oe, pin_rdy_out, pin_rdy_oe;
    logic m_valid, s_ready;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    par_sync_port #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) i_par_sync_port (
        .clk, .rst, .cfg_enable, .cfg_edge_sel, .cfg_dir_tx, .cfg_width,
        .cfg_de_pol, .cfg_rdy_pol, .cfg_hs, .pclk, .pdata_in, .pdata_out,
        .pdata_oe, .pin_de_in, .pin_de_out, .pin_de_oe, .pin_rdy_in,
        .pin_rdy_out, .pin_rdy_oe, .m_valid, .m_data, .m_ready, .s_valid,
        .s_data, .s_ready
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    // drive pclk to a level and hold it for half a parallel period
    task automatic half(logic lvl);
        @(negedge clk);
        pclk = lvl;
        wait_clks(HALF);
    endtask

    task automatic setup(logic edge_sel, logic tx, logic [1:0] w, logic dpol,
                         logic rpol, logic [2:0] hs, logic pclk0);
        @(negedge clk);
        cfg_enable = 0;
        s_valid = 0; m_ready = 0;
        wait_clks(3);
        cfg_edge_sel = edge_sel; cfg_dir_tx = tx; cfg_width = w;
        cfg_de_pol = dpol; cfg_rdy_pol = rpol; cfg_hs = hs;
        pclk = pclk0;
        wait_clks(5);
        cfg_enable = 1;
        wait_clks(3);
    endtask

    task automatic pop_one;
        @(negedge clk); m_ready = 1;
        @(negedge clk); m_ready = 0;
        wait_clks(1);
    endtask

    task automatic push_one(logic [DW-1:0] w);
        @(negedge clk); s_data = w; s_valid = 1;
        @(negedge clk); s_valid = 0;
        wait_clks(1);
    endtask

    task automatic t_reset;
        chk("R1 pdata_oe", pdata_oe, 0);
        chk("R1 pin_de_oe", pin_de_oe, 0);
        chk("R1 pin_rdy_oe", pin_rdy_oe, 0);
        chk("R1 m_valid", m_valid, 0);
        chk("R1 s_ready", s_ready, 0);
    endtask

    task automatic t_r2_edges;
        // receive, edge_sel=0 -> falling edge captures
        setup(0, 0, 2'd3, 0, 0, 3'd0, 0);
        pdata_in = 16'h1111;
        half(1);
        chk("R2 rising ignored sel0", m_valid, 0);
        half(0);
        chk("R2 falling captures sel0", m_valid, 1);
        chk("R2 falling data sel0", m_data, 16'h1111);
        pdata_in = 16'h2222;
        half(1);
        pop_one();
        chk("R2 single word sel0", m_valid, 0);
        // receive, edge_sel=1 -> rising captures
        setup(1, 0, 2'd3, 0, 0, 3'd0, 1);
        pdata_in = 16'h3333;
        half(0);
        chk("R2 falling ignored sel1", m_valid, 0);
        half(1);
        chk("R2 rising captures sel1", m_valid, 1);
        chk("R2 rising data sel1", m_data, 16'h3333);
    endtask

    task automatic t_r3_width;
        for (int c = 0; c < 4; c++) begin
            setup(0, 0, 2'(c), 0, 0, 3'd0, 1);
            pdata_in = 16'hA5C3;
            half(0);
            chk($sformatf("R3 width code %0d", c), m_data, (c == 3) ? 16'hA5C3 : 16'h00C3);
        end
        // transmit narrow: upper byte driven as zero
        setup(0, 1, 2'd0, 0, 0, 3'd0, 0);
        push_one(16'hBEEF);
        half(1);
        chk("R3 tx narrow", pdata_out, 16'h00EF);
    endtask

    task automatic t_r4_ready;
        setup(0, 0, 2'd3, 0, 1, 3'd1, 1);
        chk("R4 ready oe", pin_rdy_oe, 1);
        chk("R4 ready active high", pin_rdy_out, 1);
        for (int i = 0; i < DEPTH; i++) begin
            pdata_in = 16'(i + 1);
            half(0);
            half(1);
        end
        chk("R4 full drops ready", pin_rdy_out, 0);
        pop_one();
        chk("R4 room raises ready", pin_rdy_out, 1);
        chk("R4 order kept", m_data, 16'd2);
        setup(0, 0, 2'd3, 0, 0, 3'd1, 1);
        chk("R4 ready active low", pin_rdy_out, 0);
    endtask

    task automatic t_r5_de_gate;
        setup(0, 0, 2'd3, 0, 0, 3'd2, 1);
        chk("R5 de pin not driven in rx", pin_de_oe, 0);
        pin_de_in = 1;
        pdata_in = 16'h0505;
        half(0);
        chk("R5 inactive de blocks", m_valid, 0);
        half(1);
        pin_de_in = 0;
        half(0);
        chk("R5 active-low de captures", m_valid, 1);
        chk("R5 data", m_data, 16'h0505);
        pin_de_in = 0;
    endtask

    task automatic t_r6_tx;
        setup(0, 1, 2'd3, 1, 0, 3'd2, 0);
        chk("R6 bus oe", pdata_oe, 1);
        chk("R6 de idle level", pin_de_out, 0);
        chk("R6 de oe", pin_de_oe, 1);
        push_one(16'hCAFE);
        half(1);
        chk("R6 word driven", pdata_out, 16'hCAFE);
        chk("R6 de active", pin_de_out, 1);
        push_one(16'hF00D);
        half(0);
        chk("R6 falling no drive", pdata_out, 16'hCAFE);
        half(1);
        chk("R6 second word", pdata_out, 16'hF00D);
        half(0);
        half(1);
        chk("R6 empty de inactive", pin_de_out, 0);
        chk("R6 data held", pdata_out, 16'hF00D);
    endtask

    task automatic t_r7_tx_ready;
        setup(0, 1, 2'd3, 1, 0, 3'd3, 0);
        pin_rdy_in = 1;
        push_one(16'h7777);
        half(1);
        chk("R7 not ready holds word", pdata_out, 16'h0000);
        chk("R7 de inactive", pin_de_out, 0);
        half(0);
        pin_rdy_in = 0;
        half(1);
        chk("R7 ready sends", pdata_out, 16'h7777);
        chk("R7 de active", pin_de_out, 1);
        pin_rdy_in = 0;
    endtask

    task automatic t_r8_remap;
        // code 5: ready on data-enable pin, ready polarity high
        setup(0, 0, 2'd3, 0, 1, 3'd5, 1);
        chk("R8 code5 de pin oe", pin_de_oe, 1);
        chk("R8 code5 level uses rdy pol", pin_de_out, 1);
        chk("R8 code5 rdy pin free", pin_rdy_oe, 0);
        // code 6: data-enable on ready pin, de polarity high
        setup(0, 0, 2'd3, 1, 0, 3'd6, 1);
        pin_rdy_in = 0; pin_de_in = 1;
        pdata_in = 16'h6666;
        half(0);
        chk("R8 code6 inactive blocks", m_valid, 0);
        half(1);
        pin_rdy_in = 1; pin_de_in = 0;
        half(0);
        chk("R8 code6 active captures", m_valid, 1);
        chk("R8 code6 no pins driven", {pin_de_oe, pin_rdy_oe}, 2'b00);
        pin_rdy_in = 0;
    endtask

    task automatic t_r9_shared;
        // code 4, receive, falling edge active: drive ready only while low
        setup(0, 0, 2'd3, 1, 1, 3'd4, 1);
        chk("R9 code4 released high phase", pin_rdy_oe, 0);
        pin_rdy_in = 1;
        pdata_in = 16'h4444;
        half(0);
        chk("R9 code4 captured", m_valid, 1);
        chk("R9 code4 driven low phase", pin_rdy_oe, 1);
        chk("R9 code4 ready level", pin_rdy_out, 1);
        chk("R9 code4 de pin free", pin_de_oe, 0);
        pop_one();
        half(1);
        chk("R9 code4 released again", pin_rdy_oe, 0);
        pin_rdy_in = 0;
        half(0);
        chk("R9 code4 inactive de blocks", m_valid, 0);
        // code 7, transmit, rising edge active: drive de only while high
        setup(0, 1, 2'd3, 1, 1, 3'd7, 0);
        push_one(16'h7A7A);
        chk("R9 code7 released low phase", pin_de_oe, 0);
        pin_de_in = 1;
        half(1);
        chk("R9 code7 word sent", pdata_out, 16'h7A7A);
        chk("R9 code7 driven high phase", pin_de_oe, 1);
        chk("R9 code7 de level", pin_de_out, 1);
        pin_de_in = 0;
    endtask

    task automatic t_r10_flush;
        setup(0, 0, 2'd3, 0, 0, 3'd0, 1);
        pdata_in = 16'hAAAA;
        half(0);
        half(1);
        half(0);
        chk("R10 words held", m_valid, 1);
        @(negedge clk); cfg_enable = 0;
        wait_clks(3);
        chk("R10 disabled no valid", m_valid, 0);
        cfg_enable = 1;
        wait_clks(3);
        chk("R10 flushed after re-enable", m_valid, 0);
    endtask

    task automatic t_r11_frozen;
        setup(0, 0, 2'd3, 0, 0, 3'd0, 1);
        @(negedge clk);
        cfg_width = 2'd0; cfg_edge_sel = 1; cfg_hs = 3'd3; cfg_dir_tx = 1;
        wait_clks(2);
        chk("R11 still receive", pdata_oe, 0);
        pdata_in = 16'h9A9A;
        half(0);
        chk("R11 old edge kept", m_valid, 1);
        chk("R11 old width kept", m_data, 16'h9A9A);
        chk("R11 no handshake pins", {pin_de_oe, pin_rdy_oe}, 2'b00);
    endtask

    task automatic t_r12_free_run;
        setup(0, 0, 2'd3, 0, 0, 3'd0, 1);
        pin_de_in = 1; pin_rdy_in = 1;
        for (int i = 0; i < 3; i++) begin
            pdata_in = 16'(16'h100 + i);
            half(0);
            half(1);
        end
        chk("R12 pins free", {pin_de_oe, pin_rdy_oe}, 2'b00);
        for (int i = 0; i < 3; i++) begin
            chk("R12 every edge moves word", m_data, 32'(16'h100 + i));
            pop_one();
        end
        chk("R12 none extra", m_valid, 0);
        pin_de_in = 0; pin_rdy_in = 0;
    endtask

    initial begin
        wait_clks(4);
        @(negedge clk); rst = 0;
        wait_clks(2);
        t_reset();
        t_r2_edges();
        t_r3_width();
        t_r4_ready();
        t_r5_de_gate();
        t_r6_tx();
        t_r7_tx_ready();
        t_r8_remap();
        t_r9_shared();
        t_r10_flush();
        t_r11_frozen();
        t_r12_free_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule